// File: doc/BRIEF.md
# Weighted Event Power Accumulator

This block turns processor activity into an energy estimate. Each clock cycle it receives one strobe per event class: jump, arithmetic and coprocessor instructions, register file accesses, and cache hits and misses. For every strobe that is set it adds a programmable weight. The weights are expressed in units of one register file access. Event classes fall into three groups: instruction, pipeline and cache. Each group's subtotal is multiplied by a group scale before the groups are added together.

Cycle energies are summed over a window of k cycles. On the last cycle of each window the block presents the window total as an instant-power sample, together with a one-cycle valid pulse. Statistics logic keeps the largest sample, a saturating running sum and a sample count, so software can compute the long-run average as sum divided by count. A simple write port and a combinational read port give access to the weights, scales, window length, a clear command and the statistics.

Top module: `evpwr_meter`

## Requirements
- R1: After reset the registers hold these values: event weights jump 8, arithmetic 4, coprocessor 48, register file 4, cache hit 6, cache miss 40; the three group scales are 4; the window length is 16; peak, sum and count are 0. All weights and scales are unsigned with 2 fractional bits, so 4 means 1.0. The register addresses are: 0 jump, 1 arithmetic, 2 coprocessor, 3 register file, 4 cache hit, 5 cache miss, 6 instruction scale, 7 pipeline scale, 8 cache scale, 9 window length, 10 control, 11 last sample, 12 peak, 13 sum, 14 count.
- R2: The event strobe bits are ev_i[0] jump, [1] arithmetic, [2] coprocessor, [3] register file, [4] cache hit and [5] cache miss. Bits 0 to 2 form the instruction group, bit 3 the pipeline group and bits 4 and 5 the cache group. The energy of a cycle is floor((S0*G0 + S1*G1 + S2*G2) / 4), where Gn is the sum of the weights of the strobes set in group n and Sn is that group's scale. Any combination of strobes may be set in the same cycle.
- R3: sample_valid is high exactly on the last cycle of every k-cycle window. In that cycle sample_data equals the sum of the cycle energies of all k cycles of the window, including the current one.
- R4: A new window length takes effect only at the next window boundary; a window that is in progress keeps its length. A length of 0 behaves as 1.
- R5: The peak register holds the largest sample since the last clear. The last-sample register holds the most recent sample.
- R6: Each sample adds 1 to the count and its value to the sum.
- R7: Writing 1 to bit 0 of the control register clears peak, sum and count at the end of the write cycle. A sample that completes in that same cycle is discarded.
- R8: The window total saturates at 2^24-1 and the sum saturates at 2^32-1; neither wraps.
- R9: A weight or scale that is written reads back with the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_i | input | 6 | Per-class event strobes for this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, combinational |
| sample_valid | output | 1 | High on the last cycle of each window |
| sample_data | output | 24 | Window total, valid while sample_valid is high |

## Verification
With a one-cycle window, all 64 strobe combinations are driven twice. The first pass uses unit scales, which exposes a wrong weight or a wrong bit-to-class mapping. The second pass uses uneven scales, which separates the groups from each other and exercises the floor of the fractional result. Four-cycle windows with changing strobe patterns check that the sample covers exactly the cycles of its window. A length change written mid-window, a zero length, and a clear written in the same cycle as an active sample test the boundary rules. Long runs with every strobe at the maximum weight drive the window total and the sum into saturation.

// File: rtl/evpwr_pkg.sv
package evpwr_pkg;

   localparam int N_EVENTS = 6;
   localparam int N_GROUPS = 3;

   typedef enum logic [3:0] {
      A_W_JUMP   = 4'd0,
      A_W_ARITH  = 4'd1,
      A_W_COPROC = 4'd2,
      A_W_RFILE  = 4'd3,
      A_W_CHIT   = 4'd4,
      A_W_CMISS  = 4'd5,
      A_SC_INSTR = 4'd6,
      A_SC_PIPE  = 4'd7,
      A_SC_CACHE = 4'd8,
      A_WINDOW   = 4'd9,
      A_CTRL     = 4'd10,
      A_SAMPLE   = 4'd11,
      A_PEAK     = 4'd12,
      A_SUM      = 4'd13,
      A_COUNT    = 4'd14
   } reg_addr_e;

   // group membership of each event class: 0 instruction, 1 pipeline, 2 cache
   function automatic int unsigned event_group(int unsigned ev);
      if (ev < 3) return 0;
      else if (ev == 3) return 1;
      else return 2;
   endfunction

   // reset weight of each event class in half units
   function automatic int unsigned weight_halves(int unsigned ev);
      case (ev)
         0: return 4;
         1: return 2;
         2: return 24;
         3: return 2;
         4: return 3;
         default: return 20;
      endcase
   endfunction

endpackage

// File: rtl/evpwr_regs.sv
module evpwr_regs
   import evpwr_pkg::*;
#(
   parameter int W_W     = 8,
   parameter int S_W     = 8,
   parameter int FRAC    = 2,
   parameter int K_W     = 16,
   parameter int K_RESET = 16,
   parameter int RD_W    = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [3:0]                         wr_addr,
   input  logic [RD_W-1:0]                    wr_data,
   output logic [N_EVENTS-1:0][W_W-1:0]       weight_o,
   output logic [N_GROUPS-1:0][S_W-1:0]       scale_o,
   output logic [K_W-1:0]                     window_o,
   output logic                               clear_o
);

   localparam int WIN_ADDR   = int'(A_WINDOW);
   localparam int SCALE_BASE = int'(A_SC_INSTR);

   for (genvar i = 0; i < N_EVENTS; i++) begin : g_weight
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            weight_o[i] <= W_W'(weight_halves(i) << (FRAC - 1));
         else if (wr_en && wr_addr == 4'(i))
            weight_o[i] <= wr_data[W_W-1:0];
      end
   end

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_scale
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            scale_o[g] <= S_W'(1 << FRAC);
         else if (wr_en && wr_addr == 4'(SCALE_BASE + g))
            scale_o[g] <= wr_data[S_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         window_o <= K_W'(K_RESET);
      else if (wr_en && wr_addr == 4'(WIN_ADDR))
         window_o <= wr_data[K_W-1:0];
   end

   assign clear_o = wr_en && (wr_addr == A_CTRL) && wr_data[0];

endmodule

// File: rtl/evpwr_cycle_sum.sv
module evpwr_cycle_sum
   import evpwr_pkg::*;
#(
   parameter int W_W  = 8,
   parameter int S_W  = 8,
   parameter int FRAC = 2,
   parameter int CE_W = 19
) (
   input  logic [N_EVENTS-1:0]           ev_i,
   input  logic [N_EVENTS-1:0][W_W-1:0]  weight_i,
   input  logic [N_GROUPS-1:0][S_W-1:0]  scale_i,
   output logic [CE_W-1:0]               energy_o
);

   localparam int GS_W   = W_W + $clog2(N_EVENTS + 1);
   localparam int PROD_W = GS_W + S_W;
   localparam int TOT_W  = PROD_W + $clog2(N_GROUPS + 1);

   if (CE_W != TOT_W - FRAC) begin : g_bad_width
      $error("evpwr_cycle_sum: CE_W must equal TOT_W - FRAC");
   end

   logic [N_GROUPS-1:0][GS_W-1:0]   grp_sum;
   logic [N_GROUPS-1:0][PROD_W-1:0] grp_prod;
   logic [TOT_W-1:0]                total;

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_group
      always_comb begin
         grp_sum[g] = '0;
         for (int i = 0; i < N_EVENTS; i++) begin
            if (event_group(i) == g && ev_i[i])
               grp_sum[g] = grp_sum[g] + GS_W'(weight_i[i]);
         end
      end
      assign grp_prod[g] = PROD_W'(grp_sum[g]) * PROD_W'(scale_i[g]);
   end

   always_comb begin
      total = '0;
      for (int g = 0; g < N_GROUPS; g++)
         total = total + TOT_W'(grp_prod[g]);
   end

   assign energy_o = CE_W'(total >> FRAC);

endmodule

// File: rtl/evpwr_window.sv
module evpwr_window #(
   parameter int K_W     = 16,
   parameter int K_RESET = 16,
   parameter int ACC_W   = 24,
   parameter int CE_W    = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [K_W-1:0]   window_i,
   input  logic [CE_W-1:0]  energy_i,
   output logic             sample_valid_o,
   output logic [ACC_W-1:0] sample_data_o
);

   localparam int SW = ((ACC_W > CE_W) ? ACC_W : CE_W) + 1;
   localparam logic [SW-1:0] ACC_MAX = SW'({ACC_W{1'b1}});

   logic [K_W-1:0]   k_act;
   logic [K_W-1:0]   pos;
   logic [K_W-1:0]   k_next;
   logic [ACC_W-1:0] acc;
   logic [SW-1:0]    wide;
   logic [ACC_W-1:0] acc_next;
   logic             last;

   assign k_next   = (window_i == '0) ? K_W'(1) : window_i;
   assign last     = (pos == k_act - K_W'(1));
   assign wide     = SW'(acc) + SW'(energy_i);
   assign acc_next = (wide > ACC_MAX) ? {ACC_W{1'b1}} : wide[ACC_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k_act <= (K_RESET == 0) ? K_W'(1) : K_W'(K_RESET);
         pos   <= '0;
         acc   <= '0;
      end else if (last) begin
         k_act <= k_next;
         pos   <= '0;
         acc   <= '0;
      end else begin
         pos   <= pos + K_W'(1);
         acc   <= acc_next;
      end
   end

   assign sample_valid_o = last;
   assign sample_data_o  = acc_next;

endmodule

// File: rtl/evpwr_stats.sv
module evpwr_stats #(
   parameter int ACC_W = 24,
   parameter int SUM_W = 32,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             sample_valid_i,
   input  logic [ACC_W-1:0] sample_data_i,
   output logic [ACC_W-1:0] peak_o,
   output logic [SUM_W-1:0] sum_o,
   output logic [CNT_W-1:0] count_o,
   output logic [ACC_W-1:0] last_o
);

   logic [SUM_W:0]   sum_wide;
   logic [SUM_W-1:0] sum_next;
   logic [CNT_W-1:0] cnt_next;

   assign sum_wide = {1'b0, sum_o} + (SUM_W + 1)'(sample_data_i);
   assign sum_next = sum_wide[SUM_W] ? {SUM_W{1'b1}} : sum_wide[SUM_W-1:0];
   assign cnt_next = (&count_o) ? count_o : count_o + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peak_o  <= '0;
         sum_o   <= '0;
         count_o <= '0;
         last_o  <= '0;
      end else if (clear_i) begin
         peak_o  <= '0;
         sum_o   <= '0;
         count_o <= '0;
      end else if (sample_valid_i) begin
         if (sample_data_i > peak_o)
            peak_o <= sample_data_i;
         sum_o   <= sum_next;
         count_o <= cnt_next;
         last_o  <= sample_data_i;
      end
   end

endmodule

// File: rtl/evpwr_meter.sv
module evpwr_meter
   import evpwr_pkg::*;
#(
   parameter int W_W     = 8,
   parameter int S_W     = 8,
   parameter int FRAC    = 2,
   parameter int K_W     = 16,
   parameter int K_RESET = 16,
   parameter int ACC_W   = 24,
   parameter int SUM_W   = 32,
   parameter int CNT_W   = 16,
   parameter int RD_W    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_EVENTS-1:0] ev_i,
   input  logic                wr_en,
   input  logic [3:0]          wr_addr,
   input  logic [RD_W-1:0]     wr_data,
   input  logic [3:0]          rd_addr,
   output logic [RD_W-1:0]     rd_data,
   output logic                sample_valid,
   output logic [ACC_W-1:0]    sample_data
);

   localparam int CE_W = W_W + $clog2(N_EVENTS + 1) + S_W + $clog2(N_GROUPS + 1) - FRAC;
   localparam int SCALE_BASE = int'(A_SC_INSTR);

   if (FRAC < 1 || W_W < FRAC + 4 || S_W < FRAC + 1) begin : g_bad_fixed
      $error("evpwr_meter: weight or scale too narrow for the reset values");
   end
   if (SUM_W < ACC_W || RD_W < SUM_W || RD_W < ACC_W || RD_W < CNT_W || RD_W < K_W) begin : g_bad_stats
      $error("evpwr_meter: statistics or read width too small");
   end

   logic [N_EVENTS-1:0][W_W-1:0] w_cfg;
   logic [N_GROUPS-1:0][S_W-1:0] s_cfg;
   logic [K_W-1:0]               k_cfg;
   logic                         stat_clr;
   logic [CE_W-1:0]              energy;
   logic [ACC_W-1:0]             peak_q;
   logic [SUM_W-1:0]             sum_q;
   logic [CNT_W-1:0]             cnt_q;
   logic [ACC_W-1:0]             last_q;

   evpwr_regs #(
      .W_W(W_W), .S_W(S_W), .FRAC(FRAC), .K_W(K_W), .K_RESET(K_RESET), .RD_W(RD_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .weight_o(w_cfg), .scale_o(s_cfg), .window_o(k_cfg), .clear_o(stat_clr)
   );

   evpwr_cycle_sum #(
      .W_W(W_W), .S_W(S_W), .FRAC(FRAC), .CE_W(CE_W)
   ) u_sum (
      .ev_i(ev_i), .weight_i(w_cfg), .scale_i(s_cfg), .energy_o(energy)
   );

   evpwr_window #(
      .K_W(K_W), .K_RESET(K_RESET), .ACC_W(ACC_W), .CE_W(CE_W)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .window_i(k_cfg), .energy_i(energy),
      .sample_valid_o(sample_valid), .sample_data_o(sample_data)
   );

   evpwr_stats #(
      .ACC_W(ACC_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
   ) u_stats (
      .clk(clk), .rst_n(rst_n), .clear_i(stat_clr), .sample_valid_i(sample_valid),
      .sample_data_i(sample_data), .peak_o(peak_q), .sum_o(sum_q), .count_o(cnt_q),
      .last_o(last_q)
   );

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_EVENTS; i++)
         if (rd_addr == 4'(i)) rd_data = RD_W'(w_cfg[i]);
      for (int g = 0; g < N_GROUPS; g++)
         if (rd_addr == 4'(SCALE_BASE + g)) rd_data = RD_W'(s_cfg[g]);
      case (rd_addr)
         A_WINDOW: rd_data = RD_W'(k_cfg);
         A_SAMPLE: rd_data = RD_W'(last_q);
         A_PEAK:   rd_data = RD_W'(peak_q);
         A_SUM:    rd_data = RD_W'(sum_q);
         A_COUNT:  rd_data = RD_W'(cnt_q);
         default:  ;
      endcase
   end

endmodule

// File: rtl/evpwr_meter_chk.sv
module evpwr_meter_chk #(
   parameter int ACC_W = 24,
   parameter int SUM_W = 32,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sample_valid,
   input logic [ACC_W-1:0] sample_data,
   input logic             stat_clr,
   input logic [ACC_W-1:0] peak_q,
   input logic [SUM_W-1:0] sum_q,
   input logic [CNT_W-1:0] cnt_q
);

   // R5
   peak_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr |=> peak_q >= $past(peak_q));

   // R5
   peak_covers_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && !stat_clr) |=> peak_q >= $past(sample_data));

   // R7
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr |=> (peak_q == '0 && sum_q == '0 && cnt_q == '0));

   // R6
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && !stat_clr && !(&cnt_q)) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

   // R6
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_valid && !stat_clr) |=> $stable(cnt_q) && $stable(sum_q));

   // R8
   sum_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr |=> sum_q >= $past(sum_q));

endmodule

bind evpwr_meter evpwr_meter_chk #(
   .ACC_W(ACC_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_data(sample_data),
   .stat_clr(stat_clr), .peak_q(peak_q), .sum_q(sum_q), .cnt_q(cnt_q)
);

// File: tb/evpwr_meter_bench.sv
module evpwr_meter_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  ev_i;
   logic        wr_en;
   logic [3:0]  wr_addr;
   logic [31:0] wr_data;
   logic [3:0]  rd_addr;
   logic [31:0] rd_data;
   logic        sample_valid;
   logic [23:0] sample_data;

   int n_chk  = 0;
   int n_fail = 0;
   int wm[6];
   int sm[3];

   always #5 clk = ~clk;

   evpwr_meter u_evpwr_meter (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .sample_valid(sample_valid), .sample_data(sample_data)
   );

   task automatic check(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(int a, longint d);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, output longint v);
      rd_addr = 4'(a);
      #1;
      v = longint'(rd_data);
   endtask

   task automatic align();
      while (sample_valid !== 1'b1) tick();
      tick();
   endtask

   function automatic longint energy(int c);
      longint g0, g1, g2;
      g0 = (c[0] ? wm[0] : 0) + (c[1] ? wm[1] : 0) + (c[2] ? wm[2] : 0);
      g1 = c[3] ? wm[3] : 0;
      g2 = (c[4] ? wm[4] : 0) + (c[5] ? wm[5] : 0);
      return (sm[0] * g0 + sm[1] * g1 + sm[2] * g2) >> 2;
   endfunction

   task automatic sweep(string req);
      for (int c = 0; c < 64; c++) begin
         ev_i = 6'(c);
         #1;
         check("R3 valid each cycle when k=1", longint'(sample_valid), 1);
         check(req, longint'(sample_data), energy(c));
         tick();
      end
      ev_i = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      longint v, tot, pk, acc;
      int nv;
      wm = '{8, 4, 48, 4, 6, 40};
      sm = '{4, 4, 4};
      rst_n = 1'b0; ev_i = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset values
      for (int a = 0; a < 6; a++) begin rd(a, v); check("R1 weight reset", v, wm[a]); end
      for (int a = 6; a < 9; a++) begin rd(a, v); check("R1 scale reset", v, 4); end
      rd(9, v);  check("R1 window reset", v, 16);
      rd(12, v); check("R1 peak reset", v, 0);
      rd(13, v); check("R1 sum reset", v, 0);
      rd(14, v); check("R1 count reset", v, 0);

      // R2 sweep with unit scales, one-cycle windows
      wr(9, 1); align(); wr(10, 1);
      sweep("R2 unit scales");
      tot = 0; pk = 0;
      for (int c = 0; c < 64; c++) begin tot += energy(c); if (energy(c) > pk) pk = energy(c); end
      rd(14, v); check("R6 count after sweep", v, 64);
      rd(13, v); check("R6 sum after sweep", v, tot);
      rd(12, v); check("R5 peak after sweep", v, pk);

      // R2 uneven scales, floor of quarter units
      wr(6, 3); wr(8, 5); sm[0] = 3; sm[2] = 5;
      rd(6, v); check("R9 scale readback", v, 3);
      sweep("R2 uneven scales");
      wr(6, 4); wr(8, 4); sm[0] = 4; sm[2] = 4;

      // R5 R6 R7 short sequence and clear
      wr(10, 1);
      ev_i = 6'h01; tick();
      ev_i = 6'h04; tick();
      ev_i = 6'h02; tick();
      ev_i = 6'h00;
      rd(12, v); check("R5 peak", v, 48);
      rd(11, v); check("R5 last sample", v, 4);
      rd(13, v); check("R6 sum", v, 60);
      rd(14, v); check("R6 count", v, 3);
      ev_i = 6'h04;
      wr(10, 1);
      ev_i = 6'h00;
      rd(12, v); check("R7 peak cleared", v, 0);
      rd(13, v); check("R7 sum cleared", v, 0);
      rd(14, v); check("R7 count cleared, concurrent sample dropped", v, 0);

      // R3 four-cycle windows
      wr(9, 4); align();
      for (int w = 0; w < 6; w++) begin
         acc = 0;
         for (int j = 0; j < 4; j++) begin
            ev_i = 6'(((w * 4 + j) * 7) % 64);
            #1;
            check("R3 valid position", longint'(sample_valid), (j == 3) ? 1 : 0);
            acc += energy(int'(ev_i));
            if (j == 3) check("R3 window total", longint'(sample_data), acc);
            tick();
         end
      end
      ev_i = '0;

      // R4 mid-window change
      tick();
      wr(9, 2);
      check("R4 window keeps old length", longint'(sample_valid), 0);
      tick();
      check("R4 old window ends at 4", longint'(sample_valid), 1);
      tick();
      check("R4 new window first cycle", longint'(sample_valid), 0);
      tick();
      check("R4 new length 2", longint'(sample_valid), 1);

      // R4 zero length behaves as one
      wr(9, 0); align();
      for (int j = 0; j < 3; j++) begin
         check("R4 zero length as one", longint'(sample_valid), 1);
         tick();
      end

      // R8 saturation with maximum weights and scales
      for (int a = 0; a < 9; a++) wr(a, 255);
      rd(2, v); check("R9 weight readback", v, 255);
      wr(9, 200); align();
      ev_i = 6'h3F;
      wr(10, 1);
      nv = 0;
      while (nv < 258) begin
         if (sample_valid === 1'b1) begin
            nv++;
            if (nv == 258) check("R8 window saturates", longint'(sample_data), 24'hFFFFFF);
         end
         tick();
      end
      ev_i = '0;
      rd(14, v); check("R6 count long run", v, 258);
      rd(13, v); check("R8 sum saturates", v, 32'hFFFFFFFF);
      rd(12, v); check("R8 peak saturated", v, 24'hFFFFFF);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule